// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Period End

This block is a 16-bit up-counting timer that drives two pulse-width-modulated pins, channel A and channel B, from one sawtooth count. A 4-bit waveform code selects the count at which each period ends (TOP). TOP can be a fixed 8-, 9- or 10-bit limit, a period register, or the active compare value of channel A. The counter moves only on cycles where the timer clock enable is high. The enable stands in for a prescaler outside the block.

Each channel holds a compare value. Writes to it land in a buffer and take effect only when the period ends, so a running waveform never glitches. A 2-bit output mode per channel selects a non-inverting pin, an inverting pin, or a pin held low. Four sticky event flags record period end, the two compare matches and the period-register end. Software clears them by writing ones.

Top module: `slope_pwm_timer`

## Requirements
- R1: Waveform code 5 sets TOP to 255, code 6 to 511 and code 7 to 1023. Code 14 takes TOP from the period register, and code 15 takes it from channel A's active compare value. One period lasts TOP+1 enabled ticks.
- R2: The count rises by one on each enabled tick and returns to 0 on the enabled tick in which it equals TOP. Any waveform code other than 5, 6, 7, 14 or 15 freezes the count and raises no flag.
- R3: Output mode 2 (non-inverting) sets the pin on a tick where the count equals the channel's compare value C, and clears it on the TOP tick. When both happen on the same tick, the TOP action wins. This gives TOP−C high ticks per period when C<TOP, and none otherwise.
- R4: Output mode 3 (inverting) clears the pin on a compare match and sets it on the TOP tick, with TOP taking priority. This gives C+1 high ticks per period when C<TOP, and a pin that is always high otherwise.
- R5: Output modes 0 and 1 hold the pin low.
- R6: Flag bit 0 (overflow) is set on every enabled tick in which the count equals TOP.
- R7: Flag bit 1 is set on an enabled tick where the count matches channel A, and flag bit 2 on a match for channel B. Under code 15, bit 1 is also set on the TOP tick. Under code 14, bit 3 is set on the TOP tick.
- R8: The effective TOP is never below 3. A selected source value of 0, 1 or 2 is raised to 3, and the largest TOP is 0xFFFF.
- R9: Compare writes go to a buffer that is copied into the active compare value on the TOP tick. A period-register write takes effect on the next cycle.
- R10: Writing 1 to a bit of the flag-clear input clears that flag. A set in the same cycle wins over the clear.
- R11: With the tick enable low, the count, the pins and the flags hold their values, except that a pin in output mode 0 or 1 is forced low.
- R12: Synchronous reset zeroes the count, the pins, the flags, the buffers, the active compare values and the period register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timer clock enable |
| wave_mode | input | 4 | Waveform code selecting TOP |
| out_mode_a | input | 2 | Pin mode for channel A (2 non-inverting, 3 inverting, 0/1 low) |
| out_mode_b | input | 2 | Pin mode for channel B |
| cmp_a_wr | input | 1 | Write strobe for the channel A compare buffer |
| cmp_a_data | input | 16 | Channel A compare write data |
| cmp_b_wr | input | 1 | Write strobe for the channel B compare buffer |
| cmp_b_data | input | 16 | Channel B compare write data |
| per_wr | input | 1 | Write strobe for the period register |
| per_data | input | 16 | Period register write data |
| flag_clr | input | 4 | Write-one-to-clear mask for the flags |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin |
| flags | output | 4 | Sticky flags: 0 overflow, 1 match A, 2 match B, 3 period end |
| count | output | 16 | Current counter value |

## Verification
The assertions assume that the waveform code is not changed to a smaller TOP while the count is above that TOP. They also assume that reset is held for at least one clock before any check is trusted. The stimulus meets both assumptions. Each table vector and each directed test starts with a reset. The waveform code and the output modes are set before that reset and then held. The only mid-period change is a compare or period write made while the count is still below both the old and the new TOP.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int TMR_W     = 16;
  localparam int MODE_W    = 4;
  localparam int OMODE_W   = 2;
  localparam int NCH       = 2;
  localparam int NFLAG     = 4;

  localparam logic [MODE_W-1:0] WM_FIX8  = 4'd5;
  localparam logic [MODE_W-1:0] WM_FIX9  = 4'd6;
  localparam logic [MODE_W-1:0] WM_FIX10 = 4'd7;
  localparam logic [MODE_W-1:0] WM_PER   = 4'd14;
  localparam logic [MODE_W-1:0] WM_CMPA  = 4'd15;

  localparam int FL_OVF = 0;
  localparam int FL_CMA = 1;
  localparam int FL_CMB = 2;
  localparam int FL_PER = 3;

  localparam logic [TMR_W-1:0] LIM8      = TMR_W'((1 << 8) - 1);
  localparam logic [TMR_W-1:0] LIM9      = TMR_W'((1 << 9) - 1);
  localparam logic [TMR_W-1:0] LIM10     = TMR_W'((1 << 10) - 1);
  localparam logic [TMR_W-1:0] TOP_FLOOR = TMR_W'(3);

  function automatic logic code_runs(input logic [MODE_W-1:0] m);
    return (m == WM_FIX8) || (m == WM_FIX9) || (m == WM_FIX10) ||
           (m == WM_PER)  || (m == WM_CMPA);
  endfunction

  function automatic logic [TMR_W-1:0] floor_top(input logic [TMR_W-1:0] v);
    return (v < TOP_FLOOR) ? TOP_FLOOR : v;
  endfunction

  function automatic logic [TMR_W-1:0] pick_top(input logic [MODE_W-1:0] m,
                                                input logic [TMR_W-1:0] per,
                                                input logic [TMR_W-1:0] cmpa);
    logic [TMR_W-1:0] raw;
    case (m)
      WM_FIX8:  raw = LIM8;
      WM_FIX9:  raw = LIM9;
      WM_FIX10: raw = LIM10;
      WM_PER:   raw = per;
      WM_CMPA:  raw = cmpa;
      default:  raw = '1;
    endcase
    return floor_top(raw);
  endfunction
endpackage

// File: rtl/spwm_top_sel.sv
module spwm_top_sel
  import spwm_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [W-1:0]      per,
  input  logic [W-1:0]      cmpa_act,
  output logic [W-1:0]      top_val,
  output logic              mode_ok
);
  always_comb begin
    top_val = pick_top(mode, per, cmpa_act);
    mode_ok = code_runs(mode);
  end
endmodule

// File: rtl/spwm_counter.sv
module spwm_counter #(
  parameter int W = spwm_pkg::TMR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt,
  output logic         at_top,
  output logic         wrap_evt
);
  assign at_top   = (cnt == top_val);
  assign wrap_evt = step && at_top;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (step)    cnt <= at_top ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/spwm_channel.sv
module spwm_channel
  import spwm_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [W-1:0]       wdata,
  input  logic               step,
  input  logic               wrap_evt,
  input  logic [W-1:0]       cnt,
  input  logic [OMODE_W-1:0] omode,
  output logic [W-1:0]       cmp_act,
  output logic               match,
  output logic               pin
);
  logic [W-1:0] cmp_buf;
  logic         drive_on;
  logic         invert;

  assign match    = (cnt == cmp_act);
  assign drive_on = omode[1];
  assign invert   = omode[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (wr)       cmp_buf <= wdata;
      if (wrap_evt) cmp_act <= cmp_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 pin <= 1'b0;
    else if (!drive_on)      pin <= 1'b0;
    else if (step) begin
      if (wrap_evt)          pin <= invert;
      else if (match)        pin <= ~invert;
    end
  end
endmodule

// File: rtl/spwm_flags.sv
module spwm_flags #(
  parameter int N = spwm_pkg::NFLAG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= set_vec | (flags & ~clr_vec);
  end
endmodule

// File: rtl/slope_pwm_timer.sv
module slope_pwm_timer
  import spwm_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic [MODE_W-1:0]  wave_mode,
  input  logic [OMODE_W-1:0] out_mode_a,
  input  logic [OMODE_W-1:0] out_mode_b,
  input  logic               cmp_a_wr,
  input  logic [W-1:0]       cmp_a_data,
  input  logic               cmp_b_wr,
  input  logic [W-1:0]       cmp_b_data,
  input  logic               per_wr,
  input  logic [W-1:0]       per_data,
  input  logic [NFLAG-1:0]   flag_clr,
  output logic               pwm_a,
  output logic               pwm_b,
  output logic [NFLAG-1:0]   flags,
  output logic [W-1:0]       count
);
  logic [W-1:0]       per_reg;
  logic [W-1:0]       top_val;
  logic               mode_ok;
  logic               step;
  logic               at_top;
  logic               wrap_evt;
  logic [NFLAG-1:0]   flag_set;

  logic               ch_wr    [NCH];
  logic [W-1:0]       ch_wdata [NCH];
  logic [OMODE_W-1:0] ch_omode [NCH];
  logic [W-1:0]       ch_cmp   [NCH];
  logic               ch_match [NCH];
  logic               ch_pin   [NCH];

  always_ff @(posedge clk) begin
    if (rst)         per_reg <= '0;
    else if (per_wr) per_reg <= per_data;
  end

  spwm_top_sel #(.W(W)) u_tsel (
    .mode     (wave_mode),
    .per      (per_reg),
    .cmpa_act (ch_cmp[0]),
    .top_val  (top_val),
    .mode_ok  (mode_ok)
  );

  assign step = tick_en && mode_ok;

  spwm_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .top_val  (top_val),
    .cnt      (count),
    .at_top   (at_top),
    .wrap_evt (wrap_evt)
  );

  assign ch_wr[0]    = cmp_a_wr;
  assign ch_wr[1]    = cmp_b_wr;
  assign ch_wdata[0] = cmp_a_data;
  assign ch_wdata[1] = cmp_b_data;
  assign ch_omode[0] = out_mode_a;
  assign ch_omode[1] = out_mode_b;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    spwm_channel #(.W(W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr       (ch_wr[g]),
      .wdata    (ch_wdata[g]),
      .step     (step),
      .wrap_evt (wrap_evt),
      .cnt      (count),
      .omode    (ch_omode[g]),
      .cmp_act  (ch_cmp[g]),
      .match    (ch_match[g]),
      .pin      (ch_pin[g])
    );
  end

  assign pwm_a = ch_pin[0];
  assign pwm_b = ch_pin[1];

  always_comb begin
    flag_set         = '0;
    flag_set[FL_OVF] = wrap_evt;
    flag_set[FL_CMA] = (step && ch_match[0]) || (wrap_evt && wave_mode == WM_CMPA);
    flag_set[FL_CMB] = step && ch_match[1];
    flag_set[FL_PER] = wrap_evt && wave_mode == WM_PER;
  end

  spwm_flags #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (flag_set),
    .clr_vec (flag_clr),
    .flags   (flags)
  );
endmodule

// File: rtl/spwm_checker.sv
module spwm_checker
  import spwm_pkg::*;
#(
  parameter int W = TMR_W
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_en,
  input logic               mode_ok,
  input logic [MODE_W-1:0]  mode,
  input logic [W-1:0]       count,
  input logic [W-1:0]       top_val,
  input logic               wrap_evt,
  input logic [OMODE_W-1:0] out_mode_a,
  input logic               pwm_a,
  input logic [NFLAG-1:0]   flags
);
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> count == '0);
  p_frozen_code_r2: assert property (@(posedge clk) disable iff (rst)
    !mode_ok |=> $stable(count));
  p_noninv_top_r3: assert property (@(posedge clk) disable iff (rst)
    wrap_evt && out_mode_a == 2'd2 |=> !pwm_a);
  p_inv_top_r4: assert property (@(posedge clk) disable iff (rst)
    wrap_evt && out_mode_a == 2'd3 |=> pwm_a);
  p_pin_off_r5: assert property (@(posedge clk) disable iff (rst)
    !out_mode_a[1] |=> !pwm_a);
  p_ovf_set_r6: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> flags[FL_OVF]);
  p_per_flag_r7: assert property (@(posedge clk) disable iff (rst)
    wrap_evt && mode == WM_PER |=> flags[FL_PER]);
  p_top_floor_r8: assert property (@(posedge clk) disable iff (rst)
    mode_ok |-> top_val >= W'(3));
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(count) && $stable(flags));
endmodule

bind slope_pwm_timer spwm_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_en    (tick_en),
  .mode_ok    (mode_ok),
  .mode       (wave_mode),
  .count      (count),
  .top_val    (top_val),
  .wrap_evt   (wrap_evt),
  .out_mode_a (out_mode_a),
  .pwm_a      (pwm_a),
  .flags      (flags)
);

// File: tb/sim_slope_pwm_timer.sv
module sim_slope_pwm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [3:0]  wave_mode = 4'd5;
  logic [1:0]  out_mode_a = 2'd0, out_mode_b = 2'd0;
  logic        cmp_a_wr = 1'b0, cmp_b_wr = 1'b0, per_wr = 1'b0;
  logic [15:0] cmp_a_data = '0, cmp_b_data = '0, per_data = '0;
  logic [3:0]  flag_clr = '0;
  logic        pwm_a, pwm_b;
  logic [3:0]  flags;
  logic [15:0] count;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  slope_pwm_timer u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wave_mode(wave_mode),
    .out_mode_a(out_mode_a), .out_mode_b(out_mode_b),
    .cmp_a_wr(cmp_a_wr), .cmp_a_data(cmp_a_data),
    .cmp_b_wr(cmp_b_wr), .cmp_b_data(cmp_b_data),
    .per_wr(per_wr), .per_data(per_data), .flag_clr(flag_clr),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .flags(flags), .count(count)
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic [1:0]  oa;
    logic [1:0]  ob;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] per;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd5,  2'd2, 2'd3, 16'd64,  16'd128, 16'd0},
    '{4'd6,  2'd3, 2'd2, 16'd256, 16'd511, 16'd0},
    '{4'd7,  2'd2, 2'd2, 16'd0,   16'd1023,16'd0},
    '{4'd14, 2'd2, 2'd3, 16'd5,   16'd9,   16'd20},
    '{4'd14, 2'd3, 2'd2, 16'd2,   16'd30,  16'd1},
    '{4'd15, 2'd2, 2'd2, 16'd10,  16'd4,   16'd0},
    '{4'd15, 2'd3, 2'd3, 16'd1,   16'd0,   16'd0},
    '{4'd5,  2'd0, 2'd1, 16'd10,  16'd10,  16'd0}
  };

  function automatic int exp_top(input int m, input int a, input int per);
    int t;
    if (m == 5)       t = 255;
    else if (m == 6)  t = 511;
    else if (m == 7)  t = 1023;
    else if (m == 14) t = per;
    else              t = a;
    return (t < 3) ? 3 : t;
  endfunction

  function automatic int exp_high(input int om, input int c, input int t);
    if (om == 2) return (c < t) ? t - c : 0;
    if (om == 3) return (c < t) ? c + 1 : t + 1;
    return 0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    while (int'(count) != v) step(1);
  endtask

  task automatic load_regs(input int a, input int b, input int per);
    cmp_a_data = 16'(a); cmp_a_wr = 1'b1;
    cmp_b_data = 16'(b); cmp_b_wr = 1'b1;
    per_data   = 16'(per); per_wr = 1'b1;
    step(1);
    cmp_a_wr = 1'b0; cmp_b_wr = 1'b0; per_wr = 1'b0;
  endtask

  task automatic prime(input int m, input int oa, input int ob,
                       input int a, input int b, input int per);
    tick_en = 1'b0;
    wave_mode = 4'(m); out_mode_a = 2'(oa); out_mode_b = 2'(ob);
    do_reset();
    load_regs(a, b, per);
    tick_en = 1'b1;
    while (count == 16'd0) step(1);
    wait_cnt(0);
  endtask

  initial begin : watchdog
    #(1_500_000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    step(1);
    // R12: reset state with pins enabled and clock ticking
    out_mode_a = 2'd3; out_mode_b = 2'd3; tick_en = 1'b1;
    rst = 1'b1;
    step(3);
    chk("R12", "count in reset", int'(count), 0);
    chk("R12", "pwm_a in reset", int'(pwm_a), 0);
    chk("R12", "pwm_b in reset", int'(pwm_b), 0);
    chk("R12", "flags in reset", int'(flags), 0);

    // Table walk: R1 period, R3/R4/R5 duty, R6/R7 flags, R8 floor, R9 load
    for (int i = 0; i < NV; i++) begin
      int t, n, ha, hb;
      vec_t v;
      v = VECS[i];
      prime(int'(v.mode), int'(v.oa), int'(v.ob), int'(v.a), int'(v.b), int'(v.per));
      t = exp_top(int'(v.mode), int'(v.a), int'(v.per));
      n = 0; ha = 0; hb = 0;
      flag_clr = 4'hF;
      do begin
        n++;
        ha += int'(pwm_a);
        hb += int'(pwm_b);
        step(1);
        flag_clr = 4'h0;
      end while (count != 16'd0);
      chk("R1/R8", $sformatf("vec%0d period", i), n, t + 1);
      chk("R3/R4/R5", $sformatf("vec%0d pwm_a high ticks", i), ha,
          exp_high(int'(v.oa), int'(v.a), t));
      chk("R3/R4/R5", $sformatf("vec%0d pwm_b high ticks", i), hb,
          exp_high(int'(v.ob), int'(v.b), t));
      chk("R6", $sformatf("vec%0d overflow flag", i), int'(flags[0]), 1);
      chk("R7", $sformatf("vec%0d match A flag", i), int'(flags[1]),
          int'(v.mode == 4'd15 || int'(v.a) <= t));
      chk("R7", $sformatf("vec%0d match B flag", i), int'(flags[2]), int'(int'(v.b) <= t));
      chk("R7", $sformatf("vec%0d period flag", i), int'(flags[3]), int'(v.mode == 4'd14));
    end

    // R11: tick enable low freezes count
    prime(5, 2, 2, 100, 100, 0);
    wait_cnt(40);
    tick_en = 1'b0;
    step(5);
    chk("R11", "count held while disabled", int'(count), 40);
    tick_en = 1'b1;
    step(1);
    chk("R11", "count resumes", int'(count), 41);

    // R2: unsupported code freezes counter and raises no flag
    tick_en = 1'b1; wave_mode = 4'd4;
    do_reset();
    step(40);
    chk("R2", "count frozen for code 4", int'(count), 0);
    chk("R2", "no flags for code 4", int'(flags), 0);

    // R9: buffered compare write only takes effect at TOP
    prime(14, 2, 2, 0, 9, 20);
    wait_cnt(5);
    cmp_b_data = 16'd15; cmp_b_wr = 1'b1; step(1); cmp_b_wr = 1'b0;
    wait_cnt(12);
    chk("R9", "old compare still active", int'(pwm_b), 1);
    wait_cnt(0);
    wait_cnt(12);
    chk("R9", "new compare after TOP, before match", int'(pwm_b), 0);
    wait_cnt(17);
    chk("R9", "new compare after match", int'(pwm_b), 1);
    // R9: period register acts at once
    wait_cnt(2);
    per_data = 16'd8; per_wr = 1'b1; step(1); per_wr = 1'b0;
    wait_cnt(8);
    step(1);
    chk("R9", "wrap at new period", int'(count), 0);

    // R7: code 15 sets match A flag on TOP tick even when compare < TOP
    prime(15, 2, 2, 1, 100, 0);
    wait_cnt(0);
    wait_cnt(2);
    flag_clr = 4'b0010; step(1); flag_clr = 4'h0;
    chk("R7", "match A flag cleared before TOP", int'(flags[1]), 0);
    step(1);
    chk("R7", "match A flag set at TOP for code 15", int'(flags[1]), 1);

    // R10: clear works, and set beats clear
    wait_cnt(1);
    flag_clr = 4'b0001; step(1); flag_clr = 4'h0;
    chk("R10", "overflow flag cleared", int'(flags[0]), 0);
    wait_cnt(3);
    flag_clr = 4'b0001; step(1); flag_clr = 4'h0;
    chk("R10", "set wins over clear", int'(flags[0]), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule